// File: doc/BRIEF.md
# Prime Test Register Slave

This block sits on a memory-mapped processor bus as a slave and decides whether an unsigned 32-bit integer is prime. Software stores a candidate in the first register word. That store starts the computation. Software then reads the completion word over and over until it shows one, and then reads the verdict from its own word.

The work is iterative. Values below four and even values are settled in one screening step. Odd values are tested by trial division. The odd divisors start at three and step by two while the divisor squared does not exceed the candidate. Each division runs on a bit-serial remainder unit, so the block contains no hardware divider. Read data comes from a registered multiplexer, and no tristate driver is used.

Top module: `prime_probe_slave`

## Requirements
- R1: After reset, the operand, done and prime words all read as zero.
- R2: A write with chipselect high to word 0 stores writedata as the operand, and a read of word 0 returns it.
- R3: A write to word 0 clears done and prime at the clock edge that accepts the write. A read of word 1 or word 2 accepted on the next edge returns 0.
- R4: Once word 2 reads 1, word 1 reads 1 when the operand is prime and 0 when it is not. Bit 0 carries each flag and bits 31:1 read 0.
- R5: Operands 0 and 1 are not prime, 2 and 3 are prime, and even operands above 2 are not prime. For these, a read of word 2 accepted two edges after the write returns 1.
- R6: Odd operands of 5 and above are decided by trial division with odd divisors. Done stays at 1 until the next write to word 0.
- R7: Writes to words 1, 2 and 3 change neither the operand, the done flag nor the prime flag.
- R8: A read of word 3 returns zero.
- R9: Reads and writes made while chipselect is low are ignored, and readdata keeps its previous value.
- R10: readdata changes only at the clock edge that accepts a read, one cycle after the request, with no wait states.
- R11: A write to word 0 during a running test aborts that test and starts a new one with the new operand.
- R12: When a write to word 0 lands in the same cycle that the engine would finish, the write wins. Done stays 0 and the new operand is tested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| chipselect | input | 1 | Selects this slave for the current access |
| address | input | 2 | Word offset within the slave |
| read | input | 1 | Read request |
| write | input | 1 | Write request |
| writedata | input | 32 | Write data |
| readdata | output | 32 | Registered read data, valid one cycle after the read |

## Verification
A completion and a new start can fall in the same cycle: the engine's final step would set done at the very edge that also accepts a new write to word 0. The bench provokes this with two back-to-back operand writes. The first operand is 4, which finishes one edge after its write, and that edge is exactly the one that accepts the second write of 9. The collision is judged by reading done on the following edge, which must return 0, and by then polling until the verdict for 9 is reported as not prime.

// File: rtl/prime_probe_pkg.sv
package prime_probe_pkg;

  localparam logic [1:0] OFF_OPERAND = 2'd0;
  localparam logic [1:0] OFF_VERDICT = 2'd1;
  localparam logic [1:0] OFF_FINISH  = 2'd2;

  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_SCREEN = 2'd1,
    ENG_CHECK  = 2'd2,
    ENG_DIVIDE = 2'd3
  } eng_state_t;

endpackage

// File: rtl/prime_probe_rst_sync.sv
module prime_probe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/prime_probe_remunit.sv
module prime_probe_remunit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] rem_o
);

  localparam int CW = $clog2(DW + 1);

  logic          busy_q, busy_n;
  logic          done_q, done_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] rem_q, rem_n;
  logic [DW-1:0] dvd_q, dvd_n;
  logic [DW-1:0] dvs_q, dvs_n;
  logic [DW:0]   trial;

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    cnt_n  = cnt_q;
    rem_n  = rem_q;
    dvd_n  = dvd_q;
    dvs_n  = dvs_q;
    trial  = {rem_q, dvd_q[DW-1]};
    if (abort_i) begin
      busy_n = 1'b0;
    end else if (start_i) begin
      busy_n = 1'b1;
      cnt_n  = CW'(DW);
      rem_n  = '0;
      dvd_n  = dividend_i;
      dvs_n  = divisor_i;
    end else if (busy_q) begin
      if (trial >= {1'b0, dvs_q}) rem_n = DW'(trial - {1'b0, dvs_q});
      else                        rem_n = trial[DW-1:0];
      dvd_n = dvd_q << 1;
      cnt_n = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      dvd_q  <= '0;
      dvs_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
      rem_q  <= rem_n;
      dvd_q  <= dvd_n;
      dvs_q  <= dvs_n;
    end
  end

  assign done_o = done_q;
  assign rem_o  = rem_q;

  // R6: a finished remainder is always below the divisor it was taken against
  assert_rem_below_divisor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rem_o < dvs_q));

endmodule

// File: rtl/prime_probe_engine.sv
module prime_probe_engine
  import prime_probe_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] n_i,
  output logic          done_o,
  output logic          prime_o
);

  localparam int SW = DW + 2;

  eng_state_t    state_q, state_n;
  logic          done_q, done_n;
  logic          prime_q, prime_n;
  logic [DW-1:0] div_q, div_n;
  logic [SW-1:0] sq_q, sq_n;
  logic          rem_start;
  logic          rem_done;
  logic [DW-1:0] rem_val;

  prime_probe_remunit #(.DW(DW)) u_rem (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (rem_start),
    .abort_i    (start_i),
    .dividend_i (n_i),
    .divisor_i  (div_q),
    .done_o     (rem_done),
    .rem_o      (rem_val)
  );

  always_comb begin
    state_n   = state_q;
    done_n    = done_q;
    prime_n   = prime_q;
    div_n     = div_q;
    sq_n      = sq_q;
    rem_start = 1'b0;
    if (start_i) begin
      state_n = ENG_SCREEN;
      done_n  = 1'b0;
      prime_n = 1'b0;
    end else begin
      case (state_q)
        ENG_SCREEN: begin
          if (n_i < DW'(2)) begin
            done_n = 1'b1; prime_n = 1'b0; state_n = ENG_IDLE;
          end else if (n_i < DW'(4)) begin
            done_n = 1'b1; prime_n = 1'b1; state_n = ENG_IDLE;
          end else if (!n_i[0]) begin
            done_n = 1'b1; prime_n = 1'b0; state_n = ENG_IDLE;
          end else begin
            div_n = DW'(3); sq_n = SW'(9); state_n = ENG_CHECK;
          end
        end
        ENG_CHECK: begin
          if (sq_q > {2'b00, n_i}) begin
            done_n = 1'b1; prime_n = 1'b1; state_n = ENG_IDLE;
          end else begin
            rem_start = 1'b1; state_n = ENG_DIVIDE;
          end
        end
        ENG_DIVIDE: begin
          if (rem_done) begin
            if (rem_val == '0) begin
              done_n = 1'b1; prime_n = 1'b0; state_n = ENG_IDLE;
            end else begin
              div_n   = div_q + DW'(2);
              sq_n    = sq_q + {div_q, 2'b00} + SW'(4);
              state_n = ENG_CHECK;
            end
          end
        end
        default: state_n = ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      done_q  <= 1'b0;
      prime_q <= 1'b0;
      div_q   <= '0;
      sq_q    <= '0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      prime_q <= prime_n;
      div_q   <= div_n;
      sq_q    <= sq_n;
    end
  end

  assign done_o  = done_q;
  assign prime_o = prime_q;

  // R3: a start leaves both flags clear on the following cycle
  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && !prime_o));

  // R4: the verdict is only ever raised together with completion
  assert_prime_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prime_o |-> done_o);

  // R6: completion holds until a new start arrives
  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(prime_o)));

endmodule

// File: rtl/prime_probe_slave.sv
module prime_probe_slave
  import prime_probe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chipselect,
  input  logic [ADDR_W-1:0] address,
  input  logic              read,
  input  logic              write,
  input  logic [DATA_W-1:0] writedata,
  output logic [DATA_W-1:0] readdata
);

  logic              rst_s_n;
  logic [DATA_W-1:0] operand_q, operand_n;
  logic [DATA_W-1:0] rdata_q, rdata_n;
  logic              op_wr_en;
  logic              rd_en;
  logic              eng_done;
  logic              eng_prime;

  prime_probe_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign op_wr_en = chipselect && write && (address == ADDR_W'(OFF_OPERAND));
  assign rd_en    = chipselect && read;

  prime_probe_engine #(.DW(DATA_W)) u_eng (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start_i (op_wr_en),
    .n_i     (operand_q),
    .done_o  (eng_done),
    .prime_o (eng_prime)
  );

  always_comb begin
    operand_n = operand_q;
    if (op_wr_en) operand_n = writedata;
  end

  always_comb begin
    rdata_n = rdata_q;
    if (rd_en) begin
      if (address == ADDR_W'(OFF_OPERAND))      rdata_n = operand_q;
      else if (address == ADDR_W'(OFF_VERDICT)) rdata_n = DATA_W'(eng_prime);
      else if (address == ADDR_W'(OFF_FINISH))  rdata_n = DATA_W'(eng_done);
      else                                      rdata_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      operand_q <= '0;
      rdata_q   <= '0;
    end else begin
      operand_q <= operand_n;
      rdata_q   <= rdata_n;
    end
  end

  assign readdata = rdata_q;

  // R9 / R10: readdata moves only on an accepted read
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rd_en |=> $stable(readdata));

  // R7: the operand is only rewritten by a selected write to word 0
  assert_operand_only_word0_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !op_wr_en |=> $stable(operand_q));

  // R8: reads of word 3 deliver zero
  assert_word3_zero_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_en && address == ADDR_W'(3)) |=> (readdata == '0));

endmodule

// File: tb/prime_probe_slave_test.sv
module prime_probe_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  localparam int WATCHDOG = 150000;

  localparam logic [32:0] VEC [NVEC] = '{
    {32'd0, 1'b0}, {32'd1, 1'b0}, {32'd2, 1'b1}, {32'd3, 1'b1},
    {32'd4, 1'b0}, {32'd5, 1'b1}, {32'd9, 1'b0}, {32'd15, 1'b0},
    {32'd25, 1'b0}, {32'd49, 1'b0}, {32'd97, 1'b1}, {32'd121, 1'b0},
    {32'd221, 1'b0}, {32'd7919, 1'b1}, {32'd1000, 1'b0}, {32'd65521, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chipselect;
  logic [1:0]  address;
  logic        read;
  logic        write;
  logic [31:0] writedata;
  logic [31:0] readdata;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  prime_probe_slave uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .chipselect (chipselect),
    .address    (address),
    .read       (read),
    .write      (write),
    .writedata  (writedata),
    .readdata   (readdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d, input logic cs = 1'b1);
    chipselect = cs; address = a; writedata = d; write = 1'b1; read = 1'b0;
    @(posedge clk); @(negedge clk);
    chipselect = 1'b0; write = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d, input logic cs = 1'b1);
    chipselect = cs; address = a; read = 1'b1; write = 1'b0;
    @(posedge clk); @(negedge clk);
    chipselect = 1'b0; read = 1'b0;
    d = readdata;
  endtask

  task automatic poll_done(input string tag);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 20000 && v != 32'd1; i++) bus_read(2'd2, v);
    chk(tag, v, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      cycles++;
      if (finished) break;
    end
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    chipselect = 1'b0; address = '0; read = 1'b0; write = 1'b0; writedata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 readdata", readdata, 32'd0);
    bus_read(2'd0, rv); chk("R1 operand", rv, 32'd0);
    bus_read(2'd1, rv); chk("R1 prime", rv, 32'd0);
    bus_read(2'd2, rv); chk("R1 done", rv, 32'd0);

    // Table walk: R2, R3, R4, R5, R6
    for (int k = 0; k < NVEC; k++) begin
      logic [31:0] n;
      logic        exp_p;
      n = VEC[k][32:1];
      exp_p = VEC[k][0];
      bus_write(2'd0, n);
      bus_read(2'd2, rv); chk("R3 done cleared", rv, 32'd0);
      if (n < 4 || !n[0]) begin
        bus_read(2'd2, rv); chk("R5 fast done", rv, 32'd1);
      end else begin
        poll_done("R6 done reached");
      end
      bus_read(2'd1, rv); chk(exp_p ? "R4 prime" : "R4 composite", rv, {31'd0, exp_p});
      bus_read(2'd2, rv); chk("R6 done held", rv, 32'd1);
      bus_read(2'd0, rv); chk("R2 operand readback", rv, n);
    end

    // R3: stale prime verdict cleared by new write
    bus_write(2'd0, 32'd97); poll_done("R3 setup");
    bus_write(2'd0, 32'd221);
    bus_read(2'd1, rv); chk("R3 prime cleared", rv, 32'd0);
    poll_done("R3 done");

    // R7: writes to words 1..3 ignored (state is 221, done, not prime)
    bus_write(2'd1, 32'd1);
    bus_write(2'd2, 32'd0);
    bus_write(2'd3, 32'd7);
    bus_read(2'd0, rv); chk("R7 operand kept", rv, 32'd221);
    bus_read(2'd1, rv); chk("R7 prime kept", rv, 32'd0);
    bus_read(2'd2, rv); chk("R7 done kept", rv, 32'd1);

    // R8: word 3 reads zero
    bus_read(2'd3, rv); chk("R8 word3", rv, 32'd0);

    // R9: chipselect low ignored
    bus_write(2'd0, 32'd4, 1'b0);
    bus_read(2'd0, rv); chk("R9 write ignored", rv, 32'd221);
    bus_read(2'd1, rv, 1'b0); chk("R9 read ignored", rv, 32'd221);
    bus_read(2'd2, rv); chk("R9 done kept", rv, 32'd1);

    // R10: readdata changes only after the accepting edge
    bus_read(2'd3, rv);
    chipselect = 1'b1; address = 2'd0; read = 1'b1;
    #1; chk("R10 before edge", readdata, 32'd0);
    @(posedge clk); @(negedge clk);
    chipselect = 1'b0; read = 1'b0;
    chk("R10 after edge", readdata, 32'd221);

    // R11: abort a running test with a new operand
    bus_write(2'd0, 32'd65521);
    repeat (40) @(negedge clk);
    bus_write(2'd0, 32'd121);
    poll_done("R11 done");
    bus_read(2'd1, rv); chk("R11 verdict of new operand", rv, 32'd0);
    bus_write(2'd0, 32'd221);
    repeat (30) @(negedge clk);
    bus_write(2'd0, 32'd127);
    poll_done("R11 done 2");
    bus_read(2'd1, rv); chk("R11 verdict prime", rv, 32'd1);

    // R12: new write lands on the finishing edge of operand 4
    bus_write(2'd0, 32'd4);
    bus_write(2'd0, 32'd9);
    bus_read(2'd2, rv); chk("R12 done stays low", rv, 32'd0);
    poll_done("R12 done");
    bus_read(2'd1, rv); chk("R12 verdict", rv, 32'd0);
    bus_read(2'd0, rv); chk("R12 operand", rv, 32'd9);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule